// File: doc/BRIEF.md
# Prefixed Byte-Command Register Decoder

This block accepts a stream of command bytes, one byte per accepted handshake, and decodes framed commands for a display controller. Each command opens with a fixed prefix byte and an opcode. A register-write command updates one entry of an internal 256-entry byte register file. A copy command is reported on a one-cycle strobe, together with its decoded source address, destination address and pixel count. A few committed registers are also brought out as decoded outputs: the blanking mode, the colour-depth bit and two 24-bit base addresses. An arbitrary register can be read through a combinational read port.

A write to register 0xFF controls a lock. While the lock is held, register writes are held back in a shadow copy. Releasing the lock moves every held value into the committed file in one clock, so a complete video timing group takes effect at once. Bytes that break the framing raise a sticky error flag, and the decoder then waits for the next prefix byte.

The parser is a state machine with these states:
- `ST_HUNT`: waiting for a prefix.
- `ST_OPCODE`: waiting for the opcode.
- `ST_REG_ADDR`, `ST_REG_VAL`: the two bytes of a register write.
- `ST_CP_SRC`, `ST_CP_CNT`, `ST_CP_DST`: the source address, the pixel count and the destination address of a copy.

Its transitions are:
- HUNT→OPCODE on 0xAF. HUNT→HUNT on any other byte, which raises the error flag.
- OPCODE→REG_ADDR on 0x20. OPCODE→CP_SRC on 0x6A. OPCODE→HUNT on any other opcode, which raises the error flag.
- REG_ADDR→REG_VAL, then REG_VAL→HUNT.
- CP_SRC stays in CP_SRC for three bytes, then goes to CP_CNT. CP_CNT→CP_DST. CP_DST stays in CP_DST for three bytes, then goes to HUNT.

Top module: `cmd_stream_decoder`

## Requirements
- R1: The register-write command is the four bytes 0xAF, 0x20, address, value. When the block is unlocked, `rd_data` at that address shows the value in the cycle after the value byte is accepted.
- R2: Writing 0x00 to address 0xFF sets `locked`. While `locked` is high, later writes change neither `rd_data`, `blank_mode` nor the base-address outputs.
- R3: Writing 0xFF to address 0xFF clears `locked`. Every value written while locked then becomes visible in the same cycle, the cycle after the unlock byte. For repeated writes to one address, the last one wins.
- R4: Writing any value other than 0x00 or 0xFF to address 0xFF changes neither the lock state nor any register. Address 0xFF always reads 0x00.
- R5: `blank_mode` is register 0x1F. Its codes are 0x00 (syncs on), 0x01 (blank but powered), 0x05 (standby) and 0x07 (power-down).
- R6: `base16_addr` is {reg 0x20, reg 0x21, reg 0x22} and `base8_addr` is {reg 0x26, reg 0x27, reg 0x28}, with the most significant byte first. `depth_24` is bit 0 of register 0x00, where 1 means 24bpp and 0 means 16bpp.
- R7: The copy command is the nine bytes 0xAF, 0x6A, three source bytes, one count byte and three destination bytes, each address sent most significant byte first. In the cycle after the last byte is accepted, `copy_valid` is high for exactly one cycle, with `copy_src`, `copy_count` and `copy_dst` holding the decoded fields.
- R8: A byte other than 0xAF that arrives where a prefix is expected is discarded and sets `proto_err`. The flag stays set until reset. Decoding restarts at the next 0xAF.
- R9: An opcode other than 0x20 or 0x6A sets `proto_err` and abandons the command. The bytes that follow are treated as prefix candidates.
- R10: After reset the block is unlocked, `proto_err` and `copy_valid` are low, register 0x1F reads 0x07, and every other register reads 0x00.
- R11: A byte is taken only in a cycle with `in_valid` high; `in_ready` is always high. Idle cycles inside a command have no effect, whatever `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Byte accepted (always high) |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Committed value at `rd_addr` |
| blank_mode | output | 8 | Committed register 0x1F |
| depth_24 | output | 1 | Bit 0 of register 0x00 |
| base16_addr | output | 24 | Registers 0x20..0x22 |
| base8_addr | output | 24 | Registers 0x26..0x28 |
| locked | output | 1 | Video register lock held |
| copy_valid | output | 1 | One-cycle copy command strobe |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |
| proto_err | output | 1 | Sticky framing error |

## Verification
Every result is due one clock after the accepting edge of the byte that completes it:
- a register value, through the combinational read port;
- the bulk commit on unlock;
- the `copy_valid` strobe;
- the rise of the error flag.

The bench drives each byte at a falling edge and removes it at the next falling edge. It then samples at that falling edge, or 1 ns later for read-port results, which is exactly the cycle in which the result first appears. It looks once more a cycle later to confirm that the copy strobe has dropped. Every byte is followed by an idle cycle carrying a misleading data value, so stall tolerance is exercised throughout.

// File: rtl/cmdstream_pkg.sv
package cmdstream_pkg;
    localparam logic [7:0] CMD_PREFIX  = 8'hAF;
    localparam logic [7:0] OP_REGWR    = 8'h20;
    localparam logic [7:0] OP_COPY     = 8'h6A;
    localparam logic [7:0] LOCK_ADDR   = 8'hFF;
    localparam logic [7:0] LOCK_VAL    = 8'h00;
    localparam logic [7:0] UNLOCK_VAL  = 8'hFF;
    localparam logic [7:0] BLANK_ADDR  = 8'h1F;
    localparam logic [7:0] BLANK_RESET = 8'h07;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_OPCODE,
        ST_REG_ADDR,
        ST_REG_VAL,
        ST_CP_SRC,
        ST_CP_CNT,
        ST_CP_DST
    } parse_st_t;
endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
    import cmdstream_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    output logic                    wr_en,
    output logic [7:0]              wr_addr,
    output logic [7:0]              wr_data,
    output logic                    copy_valid,
    output logic [8*ADDR_BYTES-1:0] copy_src,
    output logic [7:0]              copy_count,
    output logic [8*ADDR_BYTES-1:0] copy_dst,
    output logic                    proto_err
);
    localparam int AW = 8 * ADDR_BYTES;
    localparam int IW = $clog2(ADDR_BYTES + 1);

    parse_st_t         state_q, state_d;
    logic [IW-1:0]     idx_q;
    logic              last_byte;
    logic              bad_byte;
    logic [7:0]        addr_q;
    logic [AW-1:0]     src_q, dst_q;
    logic [7:0]        cnt_q;
    logic              strobe_q, err_q;

    assign last_byte = (idx_q == IW'(ADDR_BYTES - 1));

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        bad_byte = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (in_data == CMD_PREFIX) state_d = ST_OPCODE;
                    else                       bad_byte = 1'b1;
                end
                ST_OPCODE: begin
                    if (in_data == OP_REGWR)     state_d = ST_REG_ADDR;
                    else if (in_data == OP_COPY) state_d = ST_CP_SRC;
                    else begin
                        state_d  = ST_HUNT;
                        bad_byte = 1'b1;
                    end
                end
                ST_REG_ADDR: state_d = ST_REG_VAL;
                ST_REG_VAL:  state_d = ST_HUNT;
                ST_CP_SRC:   if (last_byte) state_d = ST_CP_CNT;
                ST_CP_CNT:   state_d = ST_CP_DST;
                ST_CP_DST:   if (last_byte) state_d = ST_HUNT;
                default:     state_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Output and field registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            addr_q   <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (bad_byte) err_q <= 1'b1;
            if (in_valid) begin
                case (state_q)
                    ST_OPCODE:   idx_q  <= '0;
                    ST_REG_ADDR: addr_q <= in_data;
                    ST_CP_SRC: begin
                        src_q <= {src_q[AW-9:0], in_data};
                        idx_q <= last_byte ? '0 : idx_q + 1'b1;
                    end
                    ST_CP_CNT:   cnt_q <= in_data;
                    ST_CP_DST: begin
                        dst_q <= {dst_q[AW-9:0], in_data};
                        idx_q <= last_byte ? '0 : idx_q + 1'b1;
                        if (last_byte) strobe_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_en      = in_valid && (state_q == ST_REG_VAL);
    assign wr_addr    = addr_q;
    assign wr_data    = in_data;
    assign copy_valid = strobe_q;
    assign copy_src   = src_q;
    assign copy_count = cnt_q;
    assign copy_dst   = dst_q;
    assign proto_err  = err_q;
endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
    import cmdstream_pkg::*;
#(
    parameter int NREGS = 256,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic                     locked,
    output logic [DW-1:0]            regs [NREGS]
);
    localparam int RAW = $clog2(NREGS);

    logic            lock_q;
    logic            ctl_hit, lock_hit, unlock_hit, data_hit;
    logic [DW-1:0]   shadow [NREGS];
    logic [NREGS-1:0] dirty;

    assign ctl_hit    = wr_en && (wr_addr == LOCK_ADDR[RAW-1:0]);
    assign lock_hit   = ctl_hit && (wr_data == DW'(LOCK_VAL));
    assign unlock_hit = ctl_hit && (wr_data == DW'(UNLOCK_VAL));
    assign data_hit   = wr_en && !ctl_hit;

    always_ff @(posedge clk) begin
        if (!rst_n)          lock_q <= 1'b0;
        else if (lock_hit)   lock_q <= 1'b1;
        else if (unlock_hit) lock_q <= 1'b0;
    end

    for (genvar i = 0; i < NREGS; i++) begin : g_entry
        localparam logic [DW-1:0] RST_V =
            (i == int'(BLANK_ADDR)) ? DW'(BLANK_RESET) : '0;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i]   <= RST_V;
                shadow[i] <= '0;
                dirty[i]  <= 1'b0;
            end else if (unlock_hit) begin
                if (dirty[i]) regs[i] <= shadow[i];
                dirty[i] <= 1'b0;
            end else if (data_hit && (wr_addr == RAW'(i))) begin
                if (lock_q) begin
                    shadow[i] <= wr_data;
                    dirty[i]  <= 1'b1;
                end else begin
                    regs[i] <= wr_data;
                end
            end
        end
    end

    assign locked = lock_q;
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import cmdstream_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    output logic                    in_ready,
    input  logic [7:0]              rd_addr,
    output logic [7:0]              rd_data,
    output logic [7:0]              blank_mode,
    output logic                    depth_24,
    output logic [23:0]             base16_addr,
    output logic [23:0]             base8_addr,
    output logic                    locked,
    output logic                    copy_valid,
    output logic [8*ADDR_BYTES-1:0] copy_src,
    output logic [7:0]              copy_count,
    output logic [8*ADDR_BYTES-1:0] copy_dst,
    output logic                    proto_err
);
    localparam int NREGS = 256;

    logic       wr_en;
    logic [7:0] wr_addr, wr_data;
    logic [7:0] regs [NREGS];

    cmd_parser #(.ADDR_BYTES(ADDR_BYTES)) i_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .copy_valid (copy_valid),
        .copy_src   (copy_src),
        .copy_count (copy_count),
        .copy_dst   (copy_dst),
        .proto_err  (proto_err)
    );

    shadow_reg_bank #(.NREGS(NREGS), .DW(8)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .locked  (locked),
        .regs    (regs)
    );

    assign in_ready    = 1'b1;
    assign rd_data     = regs[rd_addr];
    assign blank_mode  = regs[BLANK_ADDR];
    assign depth_24    = regs[8'h00][0];
    assign base16_addr = {regs[8'h20], regs[8'h21], regs[8'h22]};
    assign base8_addr  = {regs[8'h26], regs[8'h27], regs[8'h28]};
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk #(
    parameter int ADDR_BYTES = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [7:0]              in_data,
    input logic                    in_ready,
    input logic [7:0]              rd_addr,
    input logic [7:0]              rd_data,
    input logic [7:0]              blank_mode,
    input logic                    depth_24,
    input logic [23:0]             base16_addr,
    input logic [23:0]             base8_addr,
    input logic                    locked,
    input logic                    copy_valid,
    input logic [8*ADDR_BYTES-1:0] copy_src,
    input logic [7:0]              copy_count,
    input logic [8*ADDR_BYTES-1:0] copy_dst,
    input logic                    proto_err
);
    p_copy_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |=> !copy_valid);
    p_copy_after_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> $past(in_valid));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    p_err_on_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past(in_valid));
    p_lock_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (!locked || $stable(blank_mode)));
    p_lock_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (!locked || ($stable(base16_addr) && $stable(base8_addr))));
    p_ctl_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 8'hFF) |-> (rd_data == 8'h00));
    p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready);
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk #(.ADDR_BYTES(ADDR_BYTES)) i_chk (.*);

// File: tb/test_cmd_stream_decoder.sv
module test_cmd_stream_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h33;
    logic        in_ready;
    logic [7:0]  rd_addr = 8'h00;
    logic [7:0]  rd_data, blank_mode, copy_count;
    logic        depth_24, locked, copy_valid, proto_err;
    logic [23:0] base16_addr, base8_addr, copy_src, copy_dst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmd_stream_decoder i_cmd_stream_decoder (.*);

    // {address, value} pairs written while unlocked, read back via R1
    localparam logic [15:0] WR_TAB [6] = '{
        16'h053C, 16'h1F00, 16'h2012, 16'h2134, 16'h2256, 16'h0001
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hAF;   // idle cycle with a prefix-looking byte (R11)
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        send(8'hAF); send(8'h20); send(a); send(v);
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(req, {24'h0, rd_data}, {24'h0, exp});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R10 reset state
        chk("R10 blank", {24'h0, blank_mode}, 32'h07);
        chk("R10 locked", {31'h0, locked}, 32'h0);
        chk("R10 err", {31'h0, proto_err}, 32'h0);
        chk("R10 copy_valid", {31'h0, copy_valid}, 32'h0);
        rdchk("R10 reg05", 8'h05, 8'h00);
        rdchk("R10 reg1F", 8'h1F, 8'h07);

        // R1 table walk
        foreach (WR_TAB[k]) begin
            wr(WR_TAB[k][15:8], WR_TAB[k][7:0]);
            rdchk("R1 table", WR_TAB[k][15:8], WR_TAB[k][7:0]);
        end
        chk("R5 blank on", {24'h0, blank_mode}, 32'h00);
        chk("R6 base16", {8'h0, base16_addr}, 32'h123456);
        chk("R6 depth24", {31'h0, depth_24}, 32'h1);

        // R2 lock holds writes back
        wr(8'hFF, 8'h00);
        chk("R2 locked", {31'h0, locked}, 32'h1);
        wr(8'h1F, 8'h01);
        wr(8'h1F, 8'h05);   // last write wins (R3)
        wr(8'h05, 8'hAA);
        wr(8'h27, 8'h9A);
        wr(8'h20, 8'hEE);
        chk("R2 blank held", {24'h0, blank_mode}, 32'h00);
        chk("R2 base16 held", {8'h0, base16_addr}, 32'h123456);
        rdchk("R2 reg05 held", 8'h05, 8'h3C);
        // R4 other control values ignored
        wr(8'hFF, 8'h55);
        chk("R4 still locked", {31'h0, locked}, 32'h1);
        rdchk("R4 ctl reads zero", 8'hFF, 8'h00);
        // R3 unlock commits all at once
        wr(8'hFF, 8'hFF);
        chk("R3 unlocked", {31'h0, locked}, 32'h0);
        chk("R3 blank standby", {24'h0, blank_mode}, 32'h05);
        chk("R3 base16", {8'h0, base16_addr}, 32'hEE3456);
        rdchk("R3 reg05", 8'h05, 8'hAA);
        wr(8'h26, 8'h01);
        wr(8'h28, 8'h02);
        chk("R6 base8", {8'h0, base8_addr}, 32'h019A02);

        // R7 copy command (idle gaps between bytes, R11)
        send(8'hAF); send(8'h6A);
        send(8'h12); send(8'h34); send(8'h56);
        send(8'h07);
        send(8'hAB); send(8'hCD); send(8'hEF);
        chk("R7 strobe", {31'h0, copy_valid}, 32'h1);
        chk("R7 src", {8'h0, copy_src}, 32'h123456);
        chk("R7 count", {24'h0, copy_count}, 32'h07);
        chk("R7 dst", {8'h0, copy_dst}, 32'hABCDEF);
        @(negedge clk);
        chk("R7 strobe one cycle", {31'h0, copy_valid}, 32'h0);
        chk("R11 idle bytes no error", {31'h0, proto_err}, 32'h0);

        // R8 stray byte, sticky error, resync
        send(8'h33);
        chk("R8 err set", {31'h0, proto_err}, 32'h1);
        wr(8'h05, 8'h77);
        rdchk("R8 resync", 8'h05, 8'h77);
        chk("R8 err sticky", {31'h0, proto_err}, 32'h1);

        // R9 unknown opcode abandons command
        do_reset();
        chk("R10 err cleared", {31'h0, proto_err}, 32'h0);
        send(8'hAF); send(8'h99);
        chk("R9 err set", {31'h0, proto_err}, 32'h1);
        send(8'h20); send(8'h05); send(8'h11);
        rdchk("R9 abandoned", 8'h05, 8'h00);
        wr(8'h05, 8'h66);
        rdchk("R9 recovers", 8'h05, 8'h66);

        finish_run();
    end
endmodule